// File: doc/BRIEF.md
# Interval Timer Register Access Interface

This block is the byte-wide register front end for a three-channel programmable interval timer. A host reaches it through a chip select, separate read and write strobes, a 2-bit address and an 8-bit data path. Address 3 takes control words. Addresses 0 to 2 are the data ports of channels 0 to 2. The counting engine sits outside this block. Each channel gives the block its live 16-bit count and its output level. The block gives each channel a one-cycle load strobe, the 16-bit value to load, the 3-bit counting mode and the BCD flag.

A control word has four fields. Bits 7:6 select a channel, and the value 3 selects the multi-channel read-back command. Bits 5:4 select the access: 0 latches the count, 1 is low byte only, 2 is high byte only, 3 is low byte then high byte. Bits 3:1 hold the counting mode and bit 0 holds the BCD flag. Each channel has two state machines and two latches:

- **Write sequencer.** States `PTR_FIRST` and `PTR_SECOND`. A word-mode data write moves `PTR_FIRST` to `PTR_SECOND` (hold the byte) and `PTR_SECOND` back to `PTR_FIRST` (issue the load). A programming control word forces `PTR_FIRST`.
- **Read sequencer.** The same two states. A live word-mode read toggles between them. A programming control word forces `PTR_FIRST`.
- **Count latch.** States `CL_EMPTY`, `CL_LO_ONLY`, `CL_HI_ONLY`, `CL_WORD_LO` and `CL_WORD_HI`. A latch command moves `CL_EMPTY` to the state that matches the access mode. A read moves `CL_WORD_LO` to `CL_WORD_HI` and every other occupied state to `CL_EMPTY`.
- **Status latch.** A pending flag that a read-back sets and a read clears.

Top module: `tmr_bus_front`

## Requirements
- R1: After reset, every channel has access mode word (3), counting mode 3 and BCD flag 0. No load strobe is active, every latch is empty, and every byte pointer is on the first byte.
- R2: In low-only access, a data write raises that channel's `load_stb` bit for exactly one cycle, starting after the write edge, with `load_val` = {8'h00, byte}. `load_val` changes only while a strobe is active.
- R3: In high-only access, a data write loads {byte, 8'h00}.
- R4: In word access, the first data write produces no strobe. The second loads {second, first}, and the next write starts a new pair. At most one channel strobes in any cycle.
- R5: A control word with nonzero access updates only the selected channel's mode and BCD outputs, from the cycle after the write. It returns both of that channel's byte pointers to the first byte.
- R6: A latch command (access field 0) snapshots the live count. Later changes to the live count are not seen. In word access the snapshot reads low byte, then high byte, and then reads return to the live count.
- R7: A latch command is ignored while the channel still holds an unread count snapshot.
- R8: A read-back control word (bits 7:6 = 3) acts on channel n when data bit n+1 is 1. It snapshots the count when bit 5 is 0 and requests status when bit 4 is 0.
- R9: The status byte is {output level, 0, access[1:0], mode[2:0], bcd}. A new status request is ignored while a status byte is pending.
- R10: A read returns, in order of priority, a pending status byte (which clears it), then a count snapshot, then the live count.
- R11: A live read in word access alternates between the low and high byte. In high-only access it returns the high byte.
- R12: A single-byte snapshot (low-only or high-only) clears after one read. A read of address 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 2 | 0..2 channel data port, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the read cycle |
| live_cnt | input | 48 | Live counts, channel n in bits 16n+15:16n |
| out_lvl | input | 3 | Channel output levels |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Load values, channel n in bits 16n+15:16n |
| cnt_mode | output | 9 | Counting modes, channel n in bits 3n+2:3n |
| cnt_bcd | output | 3 | BCD flags |

## Verification
Each result has a fixed point in time:

- **Read data** is combinational during the read cycle. The bench samples it 1 ns after driving the read at the falling edge, before the rising edge that applies the read's side effects.
- **`load_stb` and `load_val`** are registered. They appear after the rising edge that takes the write, and the bench checks them at the next falling edge, while the strobe is still high.
- **Mode and BCD outputs** are also checked at that falling edge.
- **Latch effects** are checked through the read data of the reads that follow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        PTR_FIRST  = 1'b0,
        PTR_SECOND = 1'b1
    } ptr_e;

    typedef enum logic [2:0] {
        CL_EMPTY   = 3'd0,
        CL_LO_ONLY = 3'd1,
        CL_HI_ONLY = 3'd2,
        CL_WORD_LO = 3'd3,
        CL_WORD_HI = 3'd4
    } cl_e;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
    parameter int NCH = 3,
    parameter int AW  = 2,
    parameter int DW  = 8
) (
    input  logic           cs,
    input  logic           wr,
    input  logic           rd,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] prog,
    output logic [NCH-1:0] lcnt,
    output logic [NCH-1:0] lsts,
    output logic [NCH-1:0] data_we,
    output logic [NCH-1:0] data_rd
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);
    localparam logic [1:0]    RB_CODE   = 2'(NCH);

    logic       ctl_wr;
    logic [1:0] sel;
    logic [1:0] acc;
    logic       is_rb;

    assign ctl_wr = cs && wr && (addr == CTRL_ADDR);
    assign sel    = wdata[7:6];
    assign acc    = wdata[5:4];
    assign is_rb  = (sel == RB_CODE);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit        = !is_rb && (sel == 2'(i));
        assign prog[i]    = ctl_wr && hit && (acc != 2'd0);
        assign lcnt[i]    = ctl_wr && ((hit && (acc == 2'd0)) ||
                                       (is_rb && !wdata[5] && wdata[i+1]));
        assign lsts[i]    = ctl_wr && is_rb && !wdata[4] && wdata[i+1];
        assign data_we[i] = cs && wr && (addr == AW'(i));
        assign data_rd[i] = cs && rd && !wr && (addr == AW'(i));
    end
endmodule

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog,
    input  logic          data_we,
    input  acc_e          acc,
    input  logic [DW-1:0] wdata,
    output logic          load_stb,
    output logic [CW-1:0] load_val
);
    ptr_e          wst;
    logic [DW-1:0] hold;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst <= PTR_FIRST;
        end else if (prog) begin
            wst <= PTR_FIRST;
        end else if (data_we && acc == ACC_WORD) begin
            unique case (wst)
                PTR_FIRST:  wst <= PTR_SECOND;
                PTR_SECOND: wst <= PTR_FIRST;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stb <= 1'b0;
            load_val <= '0;
            hold     <= '0;
        end else begin
            load_stb <= 1'b0;
            if (data_we) begin
                unique case (acc)
                    ACC_LO: begin
                        load_stb <= 1'b1;
                        load_val <= {{(CW-DW){1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load_stb <= 1'b1;
                        load_val <= {wdata, {(CW-DW){1'b0}}};
                    end
                    ACC_WORD: begin
                        if (wst == PTR_FIRST) begin
                            hold <= wdata;
                        end else begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, hold};
                        end
                    end
                    ACC_LATCH: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_rd_seq.sv
module tmr_rd_seq
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16,
    parameter int MW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog,
    input  logic          lcnt,
    input  logic          lsts,
    input  logic          rd_en,
    input  acc_e          acc,
    input  logic [MW-1:0] mode,
    input  logic          bcd,
    input  logic          out_lvl,
    input  logic [CW-1:0] live,
    output logic [DW-1:0] rd_byte
);
    ptr_e          rptr;
    cl_e           cl;
    logic [CW-1:0] snap;
    logic          sts_pend;
    logic [DW-1:0] sts_byte;
    logic          live_rd;

    assign live_rd = rd_en && !sts_pend && (cl == CL_EMPTY);

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= PTR_FIRST;
            cl       <= CL_EMPTY;
            snap     <= '0;
            sts_pend <= 1'b0;
            sts_byte <= '0;
        end else begin
            if (prog) begin
                rptr <= PTR_FIRST;
            end else if (live_rd && acc == ACC_WORD) begin
                unique case (rptr)
                    PTR_FIRST:  rptr <= PTR_SECOND;
                    PTR_SECOND: rptr <= PTR_FIRST;
                endcase
            end

            if (lcnt && cl == CL_EMPTY) begin
                snap <= live;
                unique case (acc)
                    ACC_LO:  cl <= CL_LO_ONLY;
                    ACC_HI:  cl <= CL_HI_ONLY;
                    default: cl <= CL_WORD_LO;
                endcase
            end else if (rd_en && !sts_pend) begin
                unique case (cl)
                    CL_EMPTY:   cl <= CL_EMPTY;
                    CL_LO_ONLY: cl <= CL_EMPTY;
                    CL_HI_ONLY: cl <= CL_EMPTY;
                    CL_WORD_LO: cl <= CL_WORD_HI;
                    CL_WORD_HI: cl <= CL_EMPTY;
                    default:    cl <= CL_EMPTY;
                endcase
            end

            if (lsts && !sts_pend) begin
                sts_pend <= 1'b1;
                sts_byte <= {out_lvl, 1'b0, acc, mode, bcd};
            end else if (rd_en && sts_pend) begin
                sts_pend <= 1'b0;
            end
        end
    end

    // read data
    always_comb begin
        rd_byte = '0;
        if (sts_pend) begin
            rd_byte = sts_byte;
        end else begin
            unique case (cl)
                CL_LO_ONLY, CL_WORD_LO: rd_byte = snap[DW-1:0];
                CL_HI_ONLY, CL_WORD_HI: rd_byte = snap[CW-1:DW];
                default: begin
                    if (acc == ACC_HI || (acc == ACC_WORD && rptr == PTR_SECOND))
                        rd_byte = live[CW-1:DW];
                    else
                        rd_byte = live[DW-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_bus_front.sv
module tmr_bus_front
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8,
    parameter int CW  = 16,
    parameter int MW  = 3,
    parameter int AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH*CW-1:0] live_cnt,
    input  logic [NCH-1:0]    out_lvl,
    output logic [NCH-1:0]    load_stb,
    output logic [NCH*CW-1:0] load_val,
    output logic [NCH*MW-1:0] cnt_mode,
    output logic [NCH-1:0]    cnt_bcd
);
    localparam logic [MW-1:0] RESET_MODE = MW'(3);

    logic [NCH-1:0] prog, lcnt, lsts, data_we, data_rd;
    logic [DW-1:0]  ch_byte [NCH];

    tmr_cmd_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
        .cs(cs), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
        .prog(prog), .lcnt(lcnt), .lsts(lsts),
        .data_we(data_we), .data_rd(data_rd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        acc_e          acc;
        logic [MW-1:0] mode;
        logic          bcd;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc  <= ACC_WORD;
                mode <= RESET_MODE;
                bcd  <= 1'b0;
            end else if (prog[i]) begin
                acc  <= acc_e'(wdata[5:4]);
                mode <= wdata[MW:1];
                bcd  <= wdata[0];
            end
        end

        assign cnt_mode[i*MW +: MW] = mode;
        assign cnt_bcd[i]           = bcd;

        tmr_wr_seq #(.DW(DW), .CW(CW)) u_wr (
            .clk(clk), .rst_n(rst_n), .prog(prog[i]), .data_we(data_we[i]),
            .acc(acc), .wdata(wdata),
            .load_stb(load_stb[i]), .load_val(load_val[i*CW +: CW])
        );

        tmr_rd_seq #(.DW(DW), .CW(CW), .MW(MW)) u_rd (
            .clk(clk), .rst_n(rst_n), .prog(prog[i]), .lcnt(lcnt[i]),
            .lsts(lsts[i]), .rd_en(data_rd[i]), .acc(acc), .mode(mode),
            .bcd(bcd), .out_lvl(out_lvl[i]), .live(live_cnt[i*CW +: CW]),
            .rd_byte(ch_byte[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cs && rd && addr == AW'(i)) rdata = ch_byte[i];
        end
    end
endmodule

// File: rtl/tmr_bus_front_chk.sv
module tmr_bus_front_chk #(
    parameter int NCH = 3,
    parameter int DW  = 8,
    parameter int CW  = 16,
    parameter int MW  = 3,
    parameter int AW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr,
    input logic              rd,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     rdata,
    input logic [NCH-1:0]    load_stb,
    input logic [NCH*CW-1:0] load_val,
    input logic [NCH*MW-1:0] cnt_mode,
    input logic [NCH-1:0]    cnt_bcd
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

    assert_strobe_from_data_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != '0) |-> $past(cs && wr && addr != CTRL_ADDR));

    assert_load_val_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(load_val) |-> (load_stb != '0));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    assert_cfg_change_needs_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cnt_mode) || !$stable(cnt_bcd)) |-> $past(cs && wr && addr == CTRL_ADDR));

    assert_ctrl_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && addr == CTRL_ADDR) |-> (rdata == '0));

    assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> (load_stb == '0));
endmodule

bind tmr_bus_front tmr_bus_front_chk #(
    .NCH(NCH), .DW(DW), .CW(CW), .MW(MW), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .rdata(rdata), .load_stb(load_stb), .load_val(load_val),
    .cnt_mode(cnt_mode), .cnt_bcd(cnt_bcd)
);

// File: tb/sim_tmr_bus_front.sv
`timescale 1ns/100ps
module sim_tmr_bus_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [15:0] live [3];
    logic [47:0] live_cnt;
    logic [2:0]  out_lvl = 3'b000;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  cnt_mode;
    logic [2:0]  cnt_bcd;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [7:0]  rb;

    assign live_cnt = {live[2], live[1], live[0]};

    always #2.5 clk = ~clk;

    tmr_bus_front u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_lvl(out_lvl),
        .load_stb(load_stb), .load_val(load_val), .cnt_mode(cnt_mode),
        .cnt_bcd(cnt_bcd)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    function automatic logic [15:0] lv(input int ch);
        return load_val[ch*16 +: 16];
    endfunction

    task automatic t_reset_r1;
        live[0] = 16'hCAFE;
        chk("R1 strobe", 16'(load_stb), 16'h0);
        chk("R1 mode", 16'(cnt_mode), 16'({3'd3, 3'd3, 3'd3}));
        chk("R1 bcd", 16'(cnt_bcd), 16'h0);
        bus_read(2'd0, rb); chk("R1 first byte", 16'(rb), 16'h00FE);
        bus_read(2'd0, rb); chk("R11 second byte", 16'(rb), 16'h00CA);
    endtask

    task automatic t_low_only_r2;
        bus_write(2'd3, 8'h14);
        chk("R5 ch0 mode", 16'(cnt_mode[2:0]), 16'd2);
        chk("R5 ch1 untouched", 16'(cnt_mode[5:3]), 16'd3);
        bus_write(2'd0, 8'hA5);
        chk("R2 strobe", 16'(load_stb), 16'h1);
        chk("R2 value", lv(0), 16'h00A5);
        @(negedge clk);
        chk("R2 strobe one cycle", 16'(load_stb), 16'h0);
    endtask

    task automatic t_high_only_r3;
        bus_write(2'd3, 8'h61);
        chk("R5 ch1 mode", 16'(cnt_mode[5:3]), 16'd0);
        chk("R5 ch1 bcd", 16'(cnt_bcd), 16'b010);
        bus_write(2'd1, 8'h3C);
        chk("R3 strobe", 16'(load_stb), 16'h2);
        chk("R3 value", lv(1), 16'h3C00);
    endtask

    task automatic t_word_r4;
        bus_write(2'd3, 8'hB6);
        bus_write(2'd2, 8'h34); chk("R4 no strobe first", 16'(load_stb), 16'h0);
        bus_write(2'd2, 8'h12); chk("R4 strobe", 16'(load_stb), 16'h4);
        chk("R4 value", lv(2), 16'h1234);
        bus_write(2'd2, 8'h78); chk("R4 restart", 16'(load_stb), 16'h0);
        bus_write(2'd2, 8'h56); chk("R4 value2", lv(2), 16'h5678);
        bus_write(2'd2, 8'h11);
        bus_write(2'd3, 8'hB6);
        bus_write(2'd2, 8'h22); chk("R5 pointer reset", 16'(load_stb), 16'h0);
        bus_write(2'd2, 8'h33); chk("R5 value after reset", lv(2), 16'h3322);
    endtask

    task automatic t_live_word_r11;
        live[2] = 16'hBEEF;
        bus_read(2'd2, rb); chk("R11 lo", 16'(rb), 16'h00EF);
        bus_read(2'd2, rb); chk("R11 hi", 16'(rb), 16'h00BE);
        bus_read(2'd2, rb); chk("R11 lo again", 16'(rb), 16'h00EF);
    endtask

    task automatic t_latch_r6_r7;
        bus_write(2'd3, 8'hB6);
        live[2] = 16'hBEEF;
        bus_write(2'd3, 8'h80);
        live[2] = 16'h4321;
        bus_read(2'd2, rb); chk("R6 latched lo", 16'(rb), 16'h00EF);
        bus_read(2'd2, rb); chk("R6 latched hi", 16'(rb), 16'h00BE);
        bus_read(2'd2, rb); chk("R6 live lo", 16'(rb), 16'h0021);
        bus_read(2'd2, rb); chk("R6 live hi", 16'(rb), 16'h0043);
        live[2] = 16'h1111;
        bus_write(2'd3, 8'h80);
        live[2] = 16'h2222;
        bus_write(2'd3, 8'h80);
        bus_read(2'd2, rb); chk("R7 first latch lo", 16'(rb), 16'h0011);
        bus_read(2'd2, rb); chk("R7 first latch hi", 16'(rb), 16'h0011);
        bus_read(2'd2, rb); chk("R7 live after", 16'(rb), 16'h0022);
    endtask

    task automatic t_single_latch_r12;
        live[0] = 16'h5A6B;
        bus_write(2'd3, 8'h00);
        live[0] = 16'h0102;
        bus_read(2'd0, rb); chk("R12 single latch", 16'(rb), 16'h006B);
        bus_read(2'd0, rb); chk("R12 cleared", 16'(rb), 16'h0002);
        bus_read(2'd3, rb); chk("R12 ctrl read", 16'(rb), 16'h0000);
    endtask

    task automatic t_readback_r8_r10;
        live[0] = 16'h0A0B; live[1] = 16'h0C0D; live[2] = 16'h9999;
        out_lvl = 3'b010;
        bus_write(2'd3, 8'hC6);
        live[0] = 16'h8888; live[1] = 16'h7777;
        bus_read(2'd1, rb); chk("R9 status ch1", 16'(rb), 16'h00A1);
        bus_read(2'd1, rb); chk("R10 count after status", 16'(rb), 16'h000C);
        bus_read(2'd1, rb); chk("R10 live last", 16'(rb), 16'h0077);
        bus_read(2'd0, rb); chk("R8 status ch0", 16'(rb), 16'h0014);
        bus_read(2'd0, rb); chk("R8 count ch0", 16'(rb), 16'h000B);
        bus_read(2'd0, rb); chk("R8 live ch0", 16'(rb), 16'h0088);
        bus_read(2'd2, rb); chk("R8 ch2 unselected", 16'(rb), 16'h0099);
    endtask

    task automatic t_status_hold_r9;
        out_lvl = 3'b010;
        bus_write(2'd3, 8'hE4);
        out_lvl = 3'b000;
        bus_write(2'd3, 8'hE4);
        bus_read(2'd1, rb); chk("R9 pending kept", 16'(rb), 16'h00A1);
        bus_read(2'd1, rb); chk("R10 status cleared", 16'(rb), 16'h0077);
        bus_write(2'd3, 8'hE4);
        bus_read(2'd1, rb); chk("R9 new status", 16'(rb), 16'h0021);
    endtask

    initial begin
        live[0] = 16'h0; live[1] = 16'h0; live[2] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_low_only_r2();
        t_high_only_r3();
        t_word_r4();
        t_live_word_r11();
        t_latch_r6_r7();
        t_single_latch_r12();
        t_readback_r8_r10();
        t_status_hold_r9();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule